// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block sits on the controller side of a four-bank SDRAM. It takes the memory from power-up to a usable state and then keeps it refreshed. After reset it keeps the clock enable low, masks the data bus and drives no command while the supply and clock settle. It then raises the clock enable and issues one precharge of every bank. A train of auto-refresh commands follows, and the last step loads the mode register with a word assembled from configuration inputs. When the register-set-to-active interval has passed, it raises `ready`.

In operation an interval counter raises a refresh request at a fixed period, which is a parameter. The request is shown on `ref_pending` so that the access logic can close its open rows. The access logic reports which banks still hold an open row on `bank_open`. The sequencer issues the refresh only when no bank is open, and it drops `ready` for the row-cycle time that follows. Refresh commands always drive a zero address, because the memory steps its own internal row counter.

Top module: `sdram_initref_seq`

## Requirements
- R1: From reset release, `cke` is low, the command is NOP (cs,ras,cas,we = 0111) and `dqm` is all ones for STABLE_CYCLES cycles. One more NOP cycle then follows with `cke` high. `dqm` stays all ones until `ready` first rises, and is all zeros from then on.
- R2: The first command is precharge-all: cs,ras,cas,we = 0010 with address bit 10 set, all other address bits zero and bank select zero.
- R3: TRP_CYCLES after the precharge, INIT_REFS auto-refresh commands (0001) are issued exactly TRC_CYCLES apart. Every refresh drives the address and bank select to zero.
- R4: TRC_CYCLES after the last start-up refresh, one mode register set (0000) is issued. The address bus carries the following fields: bits 2:0 are the burst length code, bit 3 is set for interleaved order, bits 6:4 are the CAS latency, bit 8 is zero and bit 9 is the write-mode bit (bits 9,8 = 1,0 selects single write). All other bits, including bank select, are zero.
- R5: `ready` is low during start-up and rises exactly TMRD_CYCLES after the mode register set cycle.
- R6: Once `ready` has risen, `ref_pending` is raised every REFI_CYCLES cycles. The first rise comes REFI_CYCLES cycles after `ready` first rises, and the period does not depend on when refreshes are actually issued.
- R7: A refresh is issued in the cycle after one in which `ready` is high, `ref_pending` is high and `bank_open` is all zeros. While any bit of `bank_open` is set, no refresh is issued and `ref_pending` stays high.
- R8: `ready` is low from the refresh command cycle for TRC_CYCLES cycles. `ref_pending` clears after the refresh command cycle, unless a new interval has ended in that same cycle.
- R9: In every cycle not named above, the command is NOP, and the address and bank select are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_code | input | 3 | Burst length code placed in mode bits 2:0 |
| cfg_interleave | input | 1 | Interleaved burst order (mode bit 3) |
| cfg_cas_lat | input | 3 | CAS latency placed in mode bits 6:4 |
| cfg_single_write | input | 1 | Single-write mode (mode bit 9) |
| bank_open | input | NUM_BANKS | One bit per bank that holds an open row |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| dqm | output | DQM_W | Data mask, high while initializing |
| ready | output | 1 | Memory available for access commands |
| ref_pending | output | 1 | A refresh is owed; close all banks |

## Verification
The bench compares every cycle of the start-up train against an independently computed schedule. A design that counted a wait one cycle short or long would shift a command off its expected slot. A wrong mode field position would show up as a mismatched address word across several random configurations. After start-up, random `bank_open` patterns are mixed with a directed stretch in which banks stay open across a full interval. A sequencer that refreshed with open banks, dropped a held request, reset the interval on each issue or let `ready` return early would each diverge from the bench's cycle model.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    ST_STABLE, ST_CKE, ST_PALL, ST_TRP, ST_IREF, ST_ITRC,
    ST_MRS, ST_TMRD, ST_READY, ST_RREF, ST_RTRC
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  // Low ten mode-register bits; the memory decodes these positions.
  function automatic logic [9:0] mode_low_bits(input logic [2:0] burst_code,
                                               input logic       interleave,
                                               input logic [2:0] cas_lat,
                                               input logic       single_wr);
    return {single_wr, 1'b0, 1'b0, cas_lat, interleave, burst_code};
  endfunction

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int W         = 8,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= W'(RESET_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // Once expired and not reloaded, the timer stays expired (R3 spacing).
  assert_timer_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/sdram_refi_gen.sv
module sdram_refi_gen #(
  parameter int REFI_CYCLES = 1950,
  localparam int CW = $clog2(REFI_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(REFI_CYCLES - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (at_end)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // Counter never runs past the interval limit (R6).
  assert_refi_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(REFI_CYCLES - 1));
endmodule

// File: rtl/sdram_ref_gate.sv
module sdram_ref_gate #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 issue,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic                 pending,
  output logic                 grant_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (tick)   pending <= 1'b1;
    else if (issue)  pending <= 1'b0;
  end

  assign grant_ok = pending && (bank_open == '0);

  // A request not yet served is never dropped (R7).
  assert_pending_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !issue) |=> pending);
endmodule

// File: rtl/sdram_initref_seq.sv
module sdram_initref_seq
  import sdram_seq_pkg::*;
#(
  parameter int STABLE_CYCLES = 12500,
  parameter int REFI_CYCLES   = 1950,
  parameter int TRP_CYCLES    = 3,
  parameter int TRC_CYCLES    = 9,
  parameter int TMRD_CYCLES   = 2,
  parameter int INIT_REFS     = 8,
  parameter int NUM_BANKS     = 4,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cfg_burst_code,
  input  logic                 cfg_interleave,
  input  logic [2:0]           cfg_cas_lat,
  input  logic                 cfg_single_write,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic                 cke,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [ADDR_W-1:0]    addr,
  output logic [BA_W-1:0]      ba,
  output logic [DQM_W-1:0]     dqm,
  output logic                 ready,
  output logic                 ref_pending
);
  localparam int TMR_W = $clog2(STABLE_CYCLES + TRC_CYCLES + TRP_CYCLES + TMRD_CYCLES + 1);
  localparam int RC_W  = $clog2(INIT_REFS + 1);
  localparam int SR_W  = $clog2(TRC_CYCLES + 1);
  localparam int MB_W  = ADDR_W + BA_W;

  seq_state_e          state_q, state_d;
  logic                tmr_load, tmr_zero;
  logic [TMR_W-1:0]    tmr_val;
  logic [RC_W-1:0]     init_ref_cnt;
  logic                init_done, refi_tick, grant_ok, issue_ref;
  logic [3:0]          cmd;
  logic [MB_W-1:0]     mode_bus;

  sdram_wait_timer #(.W(TMR_W), .RESET_VAL(STABLE_CYCLES - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  assign init_done = (state_q == ST_READY) || (state_q == ST_RREF) || (state_q == ST_RTRC);
  assign issue_ref = (state_q == ST_RREF);

  sdram_refi_gen #(.REFI_CYCLES(REFI_CYCLES)) u_refi (
    .clk(clk), .rst_n(rst_n), .run(init_done), .tick(refi_tick));

  sdram_ref_gate #(.NUM_BANKS(NUM_BANKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .tick(refi_tick), .issue(issue_ref),
    .bank_open(bank_open), .pending(ref_pending), .grant_ok(grant_ok));

  // Each command state loads T-2 so the wait after it lasts T-1 cycles.
  always_comb begin
    tmr_load = 1'b1;
    unique case (state_q)
      ST_PALL:          tmr_val = TMR_W'(TRP_CYCLES - 2);
      ST_IREF, ST_RREF: tmr_val = TMR_W'(TRC_CYCLES - 2);
      ST_MRS:           tmr_val = TMR_W'(TMRD_CYCLES - 2);
      default: begin
        tmr_val  = '0;
        tmr_load = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    init_ref_cnt <= '0;
    else if (state_q == ST_IREF)   init_ref_cnt <= init_ref_cnt + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STABLE: if (tmr_zero) state_d = ST_CKE;
      ST_CKE:    state_d = ST_PALL;
      ST_PALL:   state_d = ST_TRP;
      ST_TRP:    if (tmr_zero) state_d = ST_IREF;
      ST_IREF:   state_d = ST_ITRC;
      ST_ITRC:   if (tmr_zero)
                   state_d = (init_ref_cnt == RC_W'(INIT_REFS)) ? ST_MRS : ST_IREF;
      ST_MRS:    state_d = ST_TMRD;
      ST_TMRD:   if (tmr_zero) state_d = ST_READY;
      ST_READY:  if (grant_ok) state_d = ST_RREF;
      ST_RREF:   state_d = ST_RTRC;
      ST_RTRC:   if (tmr_zero) state_d = ST_READY;
      default:   state_d = ST_STABLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_STABLE;
    else        state_q <= state_d;
  end

  assign mode_bus = {{(MB_W - 10){1'b0}},
                     mode_low_bits(cfg_burst_code, cfg_interleave, cfg_cas_lat, cfg_single_write)};

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    unique case (state_q)
      ST_PALL: begin
        cmd      = CMD_PRE;
        addr[10] = 1'b1;
      end
      ST_IREF, ST_RREF: cmd = CMD_REF;
      ST_MRS: begin
        cmd  = CMD_MRS;
        addr = mode_bus[ADDR_W-1:0];
        ba   = mode_bus[MB_W-1:ADDR_W];
      end
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke   = (state_q != ST_STABLE);
  assign dqm   = init_done ? '0 : '1;
  assign ready = (state_q == ST_READY);

  // ---------------- checks beside the logic ----------------
  logic            ready_seen;
  logic            ref_seen;
  logic [SR_W-1:0] since_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_seen <= 1'b0;
      ref_seen   <= 1'b0;
      since_ref  <= '0;
    end else begin
      if (ready) ready_seen <= 1'b1;
      if (cmd == CMD_REF) begin
        ref_seen  <= 1'b1;
        since_ref <= '0;
      end else if (since_ref != SR_W'(TRC_CYCLES)) begin
        since_ref <= since_ref + 1'b1;
      end
    end
  end

  assert_quiet_while_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == CMD_NOP) && (&dqm) && !ready);

  assert_pall_a10_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> addr[10] && !ready_seen);

  assert_ref_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> (addr == '0) && (ba == '0));

  assert_ref_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP && ref_seen) |-> since_ref >= SR_W'(TRC_CYCLES - 1));

  assert_mrs_after_refs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS) |-> (init_ref_cnt == RC_W'(INIT_REFS)));

  assert_ref_banks_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF && ready_seen) |-> ($past(bank_open) == '0) && $past(ref_pending));

  assert_not_ready_in_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> !ready);
endmodule

// File: tb/sdram_initref_seq_tb.sv
`timescale 1ns/1ps
module sdram_initref_seq_tb;
  localparam int STB   = 20;
  localparam int REFI  = 60;
  localparam int TRP   = 3;
  localparam int TRC   = 7;
  localparam int TMRD  = 2;
  localparam int NREF  = 8;
  localparam int NB    = 4;
  localparam int AW    = 12;
  localparam int BW    = 2;
  localparam int DW    = 2;
  localparam int RDY_C = STB + 1 + TRP + NREF * TRC + TMRD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_burst_code = '0;
  logic cfg_interleave = 1'b0;
  logic [2:0] cfg_cas_lat = '0;
  logic cfg_single_write = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, ref_pending;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  logic [DW-1:0] dqm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_initref_seq #(
    .STABLE_CYCLES(STB), .REFI_CYCLES(REFI), .TRP_CYCLES(TRP), .TRC_CYCLES(TRC),
    .TMRD_CYCLES(TMRD), .INIT_REFS(NREF), .NUM_BANKS(NB), .ADDR_W(AW), .BA_W(BW), .DQM_W(DW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_code(cfg_burst_code), .cfg_interleave(cfg_interleave),
    .cfg_cas_lat(cfg_cas_lat), .cfg_single_write(cfg_single_write), .bank_open(bank_open),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .dqm(dqm), .ready(ready), .ref_pending(ref_pending));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Mode word as an arithmetic sum of weighted fields (R4).
  function automatic int exp_mode();
    return int'(cfg_burst_code) + 8 * int'(cfg_interleave) + 16 * int'(cfg_cas_lat)
           + (cfg_single_write ? 512 : 0);
  endfunction

  // Start-up schedule, by cycle index counted from reset release.
  function automatic int exp_init_cmd(input int c);
    int first_ref;
    first_ref = STB + 1 + TRP;
    if (c == STB + 1) return 4'b0010;
    for (int k = 0; k < NREF; k++)
      if (c == first_ref + k * TRC) return 4'b0001;
    if (c == first_ref + NREF * TRC) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic string init_tag(input int cmdv, input int c);
    if (cmdv == 4'b0010) return "R2";
    if (cmdv == 4'b0001) return "R3";
    if (cmdv == 4'b0000) return "R4";
    if (c < STB) return "R1";
    return "R9";
  endfunction

  task automatic run_once(input int post_cycles, input bit directed);
    int  cmdv, expa, busy;
    bit  mpend, ref_now, tick, next_ref;
    string tag;
    cfg_burst_code   = 3'($urandom % 8);
    cfg_interleave   = 1'($urandom % 2);
    cfg_cas_lat      = 3'($urandom % 8);
    cfg_single_write = 1'($urandom % 2);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mpend = 0; ref_now = 0; busy = 0;
    for (int c = 0; c < RDY_C + post_cycles; c++) begin
      if (directed && c >= RDY_C + REFI - 5 && c < RDY_C + 2 * REFI + 10)
        bank_open = NB'(1 + ($urandom % 15));
      else if (($urandom % 2) == 0)
        bank_open = '0;
      else
        bank_open = NB'($urandom % 16);
      #1;
      cmdv = int'({cs_n, ras_n, cas_n, we_n});
      if (c < RDY_C) begin
        tag = init_tag(exp_init_cmd(c), c);
        chk(cmdv == exp_init_cmd(c), tag, "command", cmdv, exp_init_cmd(c));
        expa = (exp_init_cmd(c) == 4'b0010) ? 1024 :
               (exp_init_cmd(c) == 4'b0000) ? exp_mode() : 0;
        chk(int'({ba, addr}) == expa, tag, "addr", int'({ba, addr}), expa);
        chk(cke == (c >= STB), "R1", "cke", int'(cke), int'(c >= STB));
        chk(dqm == '1, "R1", "dqm", int'(dqm), 3);
        chk(ready == 1'b0, "R5", "ready early", int'(ready), 0);
        chk(ref_pending == 1'b0, "R6", "pending early", int'(ref_pending), 0);
      end else begin
        chk(cmdv == (ref_now ? 4'b0001 : 4'b0111), ref_now ? "R7" : "R9", "command",
            cmdv, ref_now ? 4'b0001 : 4'b0111);
        chk(int'({ba, addr}) == 0, "R9", "addr", int'({ba, addr}), 0);
        chk(ready == (busy == 0), (c == RDY_C) ? "R5" : "R8", "ready",
            int'(ready), int'(busy == 0));
        chk(ref_pending == mpend, "R6", "pending", int'(ref_pending), int'(mpend));
        chk(dqm == '0 && cke, "R1", "dqm/cke after ready", int'({cke, dqm}), 4);
        tick     = ((c - RDY_C) % REFI) == (REFI - 1);
        next_ref = (busy == 0) && mpend && (bank_open == '0);
        mpend    = tick || (mpend && !ref_now);
        busy     = next_ref ? TRC : ((busy > 0) ? busy - 1 : 0);
        ref_now  = next_ref;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_once(1200, 1'b1);
    run_once(900, 1'b0);
    // Directed configuration corner: all mode fields at maximum (R4).
    cfg_burst_code = 3'd7; cfg_interleave = 1'b1; cfg_cas_lat = 3'd7; cfg_single_write = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (STB + 1 + TRP + NREF * TRC) @(negedge clk);
    #1;
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0000, "R4", "max-field MRS cmd",
        int'({cs_n, ras_n, cas_n, we_n}), 0);
    chk(int'({ba, addr}) == 'h27f, "R4", "max-field MRS word", int'({ba, addr}), 'h27f);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule